// File: doc/BRIEF.md
# Processor Bus Command Controller

This block sits next to a processor that reports the type of each bus cycle on a 3-bit status code. It holds the code that starts each cycle and turns it into clocked, active-low command strobes for memory reads and writes, I/O reads and writes and interrupt acknowledge. It also drives the bus-control signals: an address latch pulse, a data-enable, a transfer-direction output and one pin whose meaning depends on the mode.

A strap input selects the mode. In shared-bus mode, every command waits for an arbitration grant (active low) to have been held for `GRANT_DELAY` clocks. In dedicated-I/O mode, the I/O and interrupt-acknowledge strobes ignore the grant, and the dual-use pin becomes the active-low enable for the I/O-bus transceiver. In shared-bus mode, the same pin is an active-high cascade enable for a master interrupt controller. A command-enable qualifier forces the strobes to their inactive levels. The three-state control of the command drivers is brought out as two drive-enable outputs, one for the memory group and one for the I/O group.

A cycle starts on the first rising edge that sees a status other than passive (111) while the block is idle. The address latch pulse covers the clock after that edge. Read, early-write and acknowledge strobes start one clock later, normal write strobes two clocks later, and all of them end on the edge that sees passive again.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: While reset is held, all seven strobes are high, `ale`, `den` and `dt_tx` are low, and the block is idle.
- R2: The status code held at cycle start selects the strobe. Code 0 selects `intack_n`, 1 selects `io_rd_n`, 2 selects `io_wr_early_n` and `io_wr_n`, 4 and 5 select `mem_rd_n`, and 6 selects `mem_wr_early_n` and `mem_wr_n`. Codes 3 (halt) and 7 (passive) select no strobe.
- R3: `ale` is high for exactly the one clock after the cycle-start edge, including halt cycles, and no strobe is active during that clock.
- R4: Read, early-write and acknowledge strobes go low one clock after `ale`. Normal write strobes go low one clock after that. All strobes go high on the first edge that samples passive status.
- R5: `dt_tx` is high from cycle start to cycle end for codes 2 and 6, and low for every other code.
- R6: `den` is high for as long as a permitted non-halt command strobe is active. In dedicated-I/O mode this holds for memory cycles only.
- R7: In shared-bus mode, a command can go low only once `grant_n` has been sampled low on `GRANT_DELAY` consecutive edges. The count restarts whenever `grant_n` is high.
- R8: In shared-bus mode, `grant_n` high clears `mem_cmd_oe` and `io_cmd_oe` in the same cycle, and it withdraws any command in that same cycle.
- R9: In dedicated-I/O mode, `io_cmd_oe` stays high and the I/O and acknowledge strobes do not depend on `grant_n`. Memory strobes still follow R7 and R8.
- R10: `cmd_en` low drives all strobes high, `den` low and the peripheral enable high, in the same cycle.
- R11: In dedicated-I/O mode, `cas_pden` is low while an I/O or acknowledge strobe is active, and high otherwise.
- R12: In shared-bus mode, `cas_pden` is low during the first of two interrupt-acknowledge cycles. It is high during the address-latch clock of the second cycle and low after that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_stat | input | 3 | Bus cycle status code from the processor |
| grant_n | input | 1 | Arbitration grant, active low |
| io_bus_mode | input | 1 | Strap: 1 = dedicated-I/O mode, 0 = shared-bus mode |
| cmd_en | input | 1 | Command qualifier, active high |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| mem_wr_early_n | output | 1 | Early memory write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| io_wr_early_n | output | 1 | Early I/O write strobe |
| intack_n | output | 1 | Interrupt acknowledge strobe |
| mem_cmd_oe | output | 1 | Drive enable of the memory strobes |
| io_cmd_oe | output | 1 | Drive enable of the I/O and acknowledge strobes |
| ale | output | 1 | Address latch pulse |
| den | output | 1 | Data transceiver enable, active high |
| dt_tx | output | 1 | Direction: 1 = transmit, 0 = receive |
| cas_pden | output | 1 | Cascade enable (shared) or peripheral enable, active low (dedicated) |

## Verification
The bench targets the one-clock offset between early and normal writes. A design that merged the two would show the write strobe low in the same clock as the early strobe. It drops and raises the grant in the middle of a cycle and expects the command to be withdrawn and its delay count restarted. A design with a free-running counter, or one that registered the drive enables, would assert a command too early or release the bus a clock late. It also runs back-to-back acknowledge cycles, where a design without the first-cycle mask would raise the cascade enable twice. It changes the strap between cycles to catch I/O strobes that wait for a grant in dedicated-I/O mode, and to catch the peripheral enable leaking into the shared-bus data enable.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [2:0] {
    ST_INTA    = 3'd0,
    ST_IORD    = 3'd1,
    ST_IOWR    = 3'd2,
    ST_HALT    = 3'd3,
    ST_FETCH   = 3'd4,
    ST_MEMRD   = 3'd5,
    ST_MEMWR   = 3'd6,
    ST_PASSIVE = 3'd7
  } bus_stat_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_CMD  = 2'd2,
    PH_LATE = 2'd3
  } phase_e;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
    logic inta;
  } cmd_class_t;

endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
  import bcc_pkg::*;
(
  input  bus_stat_e  kind,
  input  logic       in_cycle,
  output cmd_class_t cls
);
  always_comb begin
    cls = '0;
    if (in_cycle) begin
      unique case (kind)
        ST_INTA:            cls.inta   = 1'b1;
        ST_IORD:            cls.io_rd  = 1'b1;
        ST_IOWR:            cls.io_wr  = 1'b1;
        ST_FETCH, ST_MEMRD: cls.mem_rd = 1'b1;
        ST_MEMWR:           cls.mem_wr = 1'b1;
        default:            cls = '0;
      endcase
    end
  end

  always_comb begin
    assert ($countones(cls) <= 1);
  end
endmodule

// File: rtl/bcc_sequencer.sv
module bcc_sequencer
  import bcc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bus_stat_e stat,
  output phase_e    phase,
  output bus_stat_e kind,
  output logic      inta_second
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      kind        <= ST_PASSIVE;
      inta_second <= 1'b0;
    end else if (stat == ST_PASSIVE) begin
      phase <= PH_IDLE;
      if (phase != PH_IDLE && kind == ST_INTA)
        inta_second <= ~inta_second;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phase <= PH_ADDR;
          kind  <= stat;
          if (stat != ST_INTA)
            inta_second <= 1'b0;
        end
        PH_ADDR: phase <= PH_CMD;
        PH_CMD:  phase <= PH_LATE;
        default: phase <= PH_LATE;
      endcase
    end
  end

  // R3: the latch pulse lasts one clock
  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ADDR) |=> (phase != PH_ADDR));

  // R4: passive status ends any cycle on the next edge
  p_passive_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == ST_PASSIVE) |=> (phase == PH_IDLE));
endmodule

// File: rtl/bcc_grant_timer.sv
module bcc_grant_timer #(
  parameter int GRANT_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_n,
  output logic ready
);
  generate
    if (GRANT_DELAY == 0) begin : g_nodelay
      assign ready = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(GRANT_DELAY + 1);
      localparam logic [CW-1:0] LIMIT = CW'(GRANT_DELAY);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n || grant_n)
          cnt <= '0;
        else if (cnt != LIMIT)
          cnt <= cnt + 1'b1;
      end

      assign ready = (cnt == LIMIT);

      // R7: ready only after grant was low on the previous edge
      p_ready_after_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(!grant_n));
    end
  endgenerate
endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
  import bcc_pkg::*;
#(
  parameter int GRANT_DELAY = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_stat,
  input  logic       grant_n,
  input  logic       io_bus_mode,
  input  logic       cmd_en,
  output logic       mem_rd_n,
  output logic       mem_wr_n,
  output logic       mem_wr_early_n,
  output logic       io_rd_n,
  output logic       io_wr_n,
  output logic       io_wr_early_n,
  output logic       intack_n,
  output logic       mem_cmd_oe,
  output logic       io_cmd_oe,
  output logic       ale,
  output logic       den,
  output logic       dt_tx,
  output logic       cas_pden
);
  phase_e     phase;
  bus_stat_e  kind;
  logic       inta_second;
  logic       grant_ready;
  cmd_class_t cls;

  bcc_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat       (bus_stat_e'(bus_stat)),
    .phase      (phase),
    .kind       (kind),
    .inta_second(inta_second)
  );

  bcc_grant_timer #(.GRANT_DELAY(GRANT_DELAY)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .grant_n(grant_n),
    .ready  (grant_ready)
  );

  bcc_decode u_dec (
    .kind    (kind),
    .in_cycle(phase != PH_IDLE),
    .cls     (cls)
  );

  logic early_ph, late_ph, mem_perm, io_perm, io_class, mem_class, mce;

  assign early_ph  = (phase == PH_CMD) || (phase == PH_LATE);
  assign late_ph   = (phase == PH_LATE);
  assign mem_perm  = grant_ready && !grant_n;
  assign io_perm   = io_bus_mode || mem_perm;
  assign io_class  = cls.io_rd || cls.io_wr || cls.inta;
  assign mem_class = cls.mem_rd || cls.mem_wr;

  assign mem_rd_n       = !(cmd_en && early_ph && cls.mem_rd && mem_perm);
  assign mem_wr_early_n = !(cmd_en && early_ph && cls.mem_wr && mem_perm);
  assign mem_wr_n       = !(cmd_en && late_ph  && cls.mem_wr && mem_perm);
  assign io_rd_n        = !(cmd_en && early_ph && cls.io_rd  && io_perm);
  assign io_wr_early_n  = !(cmd_en && early_ph && cls.io_wr  && io_perm);
  assign io_wr_n        = !(cmd_en && late_ph  && cls.io_wr  && io_perm);
  assign intack_n       = !(cmd_en && early_ph && cls.inta   && io_perm);

  assign mem_cmd_oe = !grant_n;
  assign io_cmd_oe  = io_bus_mode || !grant_n;

  assign ale   = (phase == PH_ADDR);
  assign dt_tx = cls.mem_wr || cls.io_wr;
  assign den   = cmd_en && early_ph && mem_perm &&
                 (mem_class || (io_class && !io_bus_mode));

  assign mce      = (phase == PH_ADDR) && (kind == ST_INTA) && inta_second;
  assign cas_pden = io_bus_mode ? !(cmd_en && early_ph && io_class) : mce;

  // R5: write strobes only in transmit direction
  p_write_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_early_n || !io_wr_early_n) |-> dt_tx);

  // R8: grant release floats the drivers in shared mode
  p_grant_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_n && !io_bus_mode) |-> (!mem_cmd_oe && !io_cmd_oe && mem_rd_n && io_rd_n));

  // R10: qualifier low holds every strobe inactive
  p_cmd_en_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_en |-> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && intack_n && !den));

  // R4: normal write is preceded by its early strobe
  p_late_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> $past(!mem_wr_early_n));
endmodule

// File: tb/test_bus_cmd_ctrl.sv
module test_bus_cmd_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] bus_stat;
  logic grant_n, io_bus_mode, cmd_en;
  logic mem_rd_n, mem_wr_n, mem_wr_early_n, io_rd_n, io_wr_n, io_wr_early_n, intack_n;
  logic mem_cmd_oe, io_cmd_oe, ale, den, dt_tx, cas_pden;
  int total = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_cmd_ctrl #(.GRANT_DELAY(2)) i_bus_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_stat(bus_stat), .grant_n(grant_n),
    .io_bus_mode(io_bus_mode), .cmd_en(cmd_en),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_wr_early_n(mem_wr_early_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_wr_early_n(io_wr_early_n),
    .intack_n(intack_n), .mem_cmd_oe(mem_cmd_oe), .io_cmd_oe(io_cmd_oe),
    .ale(ale), .den(den), .dt_tx(dt_tx), .cas_pden(cas_pden)
  );

  function automatic logic [6:0] strobes();
    return {mem_rd_n, mem_wr_n, mem_wr_early_n, io_rd_n, io_wr_n, io_wr_early_n, intack_n};
  endfunction

  // order {mem_rd, mem_wr, mem_wr_early, io_rd, io_wr, io_wr_early, intack}
  function automatic logic [6:0] exp_str(input logic [2:0] c, input bit late);
    logic [6:0] v = 7'h7f;
    if (c == 3'd4 || c == 3'd5) v[6] = 1'b0;
    if (c == 3'd6) begin v[4] = 1'b0; if (late) v[5] = 1'b0; end
    if (c == 3'd1) v[3] = 1'b0;
    if (c == 3'd2) begin v[1] = 1'b0; if (late) v[2] = 1'b0; end
    if (c == 3'd0) v[0] = 1'b0;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0; bus_stat = 3'd7; grant_n = 0; io_bus_mode = 0; cmd_en = 1;
    step(); step();
    chk("R1 strobes", strobes(), 7'h7f);
    chk("R1 ale", ale, 0);
    chk("R1 den", den, 0);
    chk("R1 dt_tx", dt_tx, 0);
    rst_n = 1;
    step(); step();
    chk("R1 idle after reset", {ale, strobes()}, {1'b0, 7'h7f});
  endtask

  task automatic t_decode_all();
    io_bus_mode = 0; grant_n = 0; cmd_en = 1;
    step(); step();
    for (int c = 0; c < 7; c++) begin
      bit wr = (c == 2 || c == 6);
      bit xfer = (c != 3);
      bus_stat = 3'(c);
      step();
      chk("R3 ale high", ale, 1);
      chk("R3 no strobe during ale", strobes(), 7'h7f);
      chk("R5 dir addr", dt_tx, wr);
      step();
      chk("R3 ale single", ale, 0);
      chk("R2 R4 early strobes", strobes(), exp_str(3'(c), 0));
      chk("R6 den", den, xfer);
      step();
      chk("R2 R4 late strobes", strobes(), exp_str(3'(c), 1));
      chk("R5 dir late", dt_tx, wr);
      bus_stat = 3'd7;
      step();
      chk("R4 end on passive", strobes(), 7'h7f);
      chk("R6 den off", den, 0);
    end
  endtask

  task automatic t_grant_wait();
    io_bus_mode = 0; cmd_en = 1; grant_n = 1;
    step();
    bus_stat = 3'd5;
    step(); step();
    chk("R7 held without grant", mem_rd_n, 1);
    chk("R8 mem oe off", mem_cmd_oe, 0);
    chk("R8 io oe off", io_cmd_oe, 0);
    grant_n = 0;
    #1 chk("R8 oe follows grant", mem_cmd_oe, 1);
    step();
    chk("R7 one edge not enough", mem_rd_n, 1);
    step();
    chk("R7 read after delay", mem_rd_n, 0);
    grant_n = 1;
    #1 chk("R8 withdraw now", {mem_rd_n, mem_cmd_oe}, 2'b10);
    step();
    grant_n = 0;
    step();
    chk("R7 count restarted", mem_rd_n, 1);
    step();
    chk("R7 read after restart", mem_rd_n, 0);
    bus_stat = 3'd7;
    step();
  endtask

  task automatic t_io_mode();
    io_bus_mode = 1; grant_n = 1; cmd_en = 1;
    step();
    chk("R11 pden idle", cas_pden, 1);
    chk("R9 io oe", io_cmd_oe, 1);
    bus_stat = 3'd1;
    step();
    chk("R11 pden during ale", cas_pden, 1);
    step();
    chk("R9 io read without grant", io_rd_n, 0);
    chk("R11 pden active", cas_pden, 0);
    chk("R6 den not for io", den, 0);
    bus_stat = 3'd7;
    step();
    chk("R11 pden released", cas_pden, 1);
    bus_stat = 3'd5;
    step(); step();
    chk("R9 mem still waits", mem_rd_n, 1);
    grant_n = 0;
    step(); step();
    chk("R9 mem after delay", mem_rd_n, 0);
    chk("R6 den for mem", den, 1);
    chk("R11 pden idle in mem", cas_pden, 1);
    bus_stat = 3'd7;
    step();
  endtask

  task automatic t_cmd_en();
    io_bus_mode = 0; grant_n = 0; cmd_en = 1;
    step(); step();
    bus_stat = 3'd6;
    step(); step(); step();
    chk("R10 write active first", mem_wr_n, 0);
    cmd_en = 0;
    #1 chk("R10 strobes forced", strobes(), 7'h7f);
    chk("R10 den forced", den, 0);
    bus_stat = 3'd7; cmd_en = 1;
    step();
    io_bus_mode = 1; cmd_en = 0;
    bus_stat = 3'd2;
    step(); step(); step();
    chk("R10 io write blocked", strobes(), 7'h7f);
    chk("R10 pden forced", cas_pden, 1);
    bus_stat = 3'd7; cmd_en = 1;
    step();
  endtask

  task automatic t_inta_pair();
    io_bus_mode = 0; grant_n = 0; cmd_en = 1;
    bus_stat = 3'd5;
    step(); bus_stat = 3'd7; step();
    bus_stat = 3'd0;
    step();
    chk("R12 first masked", cas_pden, 0);
    step();
    chk("R12 first ack", intack_n, 0);
    chk("R12 first no cascade", cas_pden, 0);
    bus_stat = 3'd7;
    step();
    bus_stat = 3'd0;
    step();
    chk("R12 second cascade", cas_pden, 1);
    step();
    chk("R12 cascade ends", cas_pden, 0);
    chk("R12 second ack", intack_n, 0);
    chk("R5 ack receive", dt_tx, 0);
    bus_stat = 3'd7;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_decode_all();
    t_grant_wait();
    t_io_mode();
    t_cmd_en();
    t_inta_pair();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule